// File: doc/BRIEF.md
# Banked Register Access Window

This block is a small file of 16-bit registers reached through a four-bit byte address. Because the address space is so narrow, the registers are grouped into banks. A bank-select register sits at offset 0xE in every bank, so the host can always reach it. That register stores a 3-bit bank number, and every other offset is decoded against that number.

Banks 0 to 3 each hold seven word slots at the even offsets 0x0 to 0xC. All of these slots are plain storage except one: a read-only revision word in bank 3. The contents of every storage slot are driven out to the neighbouring logic. The three bank-1 words at offsets 0x4, 0x6 and 0x8 are also repacked into a 48-bit station address.

The host bus is synchronous and has separate read and write strobes. Read data is registered.

Top module: `banked_regwin`

## Requirements
- R1: After a synchronous reset, the selected bank is 0, every storage slot is zero, the station address is zero and the read data is zero.
- R2: A write to offset 0xE updates the selected bank in any bank, including banks 4 to 7. Only write-data bits 2:0 are kept, so writing 0xFFFB selects bank 3.
- R3: A read of offset 0xE returns 0x33 in bits 15:8, zero in bits 7:3 and the selected bank in bits 2:0. After writing 0xFFFB, the value under mask 0xFF07 is 0x3303.
- R4: In banks 0 to 3, a write to offsets 0x0 to 0xC (word slot = address bits 3:1; address bit 0 is ignored) stores the data, and a later read of the same slot returns it. The revision slot is the one exception.
- R5: The same offset in different banks addresses independent storage. A write changes only the slot of the bank that is selected at that moment.
- R6: Bank 3 offset 0xA reads {0x33, revision code}, with a revision code of 0x91 by default. A write there has no effect, and its exported storage word stays zero.
- R7: The station-address output is formed from three bank-1 words. Byte 0 is bank-1 offset 0x4 bits 7:0, byte 1 is offset 0x4 bits 15:8, and so on up to byte 5, which is offset 0x8 bits 15:8. Byte n sits at output bits 8n+7:8n.
- R8: With a bank from 4 to 7 selected, a read of offsets 0x0 to 0xC returns zero and a write there changes no storage.
- R9: Read data is captured on the clock edge that samples the read strobe. It holds its value until the next read, whatever writes happen in between.
- R10: The storage output carries bank b, slot s at bits [(b*7+s)*16 +: 16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset within the window, bit 0 ignored |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| bank_sel | output | 3 | Currently selected bank |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| regs_flat | output | 448 | All storage slots, bank-major |

## Verification
A corrupted bank number shows up at the next read of offset 0xE, one clock after the strobe. It also shows up sooner, on `bank_sel` itself, and as writes landing in the wrong slot of `regs_flat` in the cycle after the write. A storage slot that is clobbered or aliased between banks shows on `regs_flat` one clock after the offending write. It is also caught when the victim bank is read back. Faults in the read path (wrong latency, missing hold, leakage from undefined banks) appear on `rdata` at the first read, or the first idle cycle, after the fault.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] SEL_SLOT = 3'd7;  // offset 0xE
  localparam logic [SLOT_W-1:0] REV_SLOT = 3'd5;  // offset 0xA
  localparam int REV_BANK = 3;
  localparam logic [7:0] SIG_BYTE = 8'h33;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [SLOT_W-1:0] slot;
  } host_op_t;
endpackage

// File: rtl/bankwin_select.sv
module bankwin_select #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [BANK_W-1:0] wbank,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst)         bank_q <= '0;
    else if (wr_hit) bank_q <= wbank;
  end

  assert_bank_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> bank_q == $past(wbank));
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(bank_q));
endmodule

// File: rtl/bankwin_store.sv
module bankwin_store #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 7,
  parameter bit HAS_RO = 1'b0,
  parameter int RO_IDX = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [2:0]              slot,
  input  logic [DATA_W-1:0]       wdata,
  output logic [SLOTS*DATA_W-1:0] q
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (HAS_RO && s == RO_IDX) begin : g_ro
      assign q[s*DATA_W +: DATA_W] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)                       word_q <= '0;
        else if (we && slot == 3'(s))  word_q <= wdata;
      end
      assign q[s*DATA_W +: DATA_W] = word_q;
    end
  end

  assert_store_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/banked_regwin.sv
module banked_regwin
  import bankwin_pkg::*;
#(
  parameter int         DATA_W    = 16,
  parameter int         ADDR_W    = 4,
  parameter int         BANK_W    = 3,
  parameter int         NUM_BANKS = 4,
  parameter int         SLOTS     = 7,
  parameter logic [7:0] REV_CODE  = 8'h91
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [BANK_W-1:0]                 bank_sel,
  output logic [47:0]                       station_addr,
  output logic [NUM_BANKS*SLOTS*DATA_W-1:0] regs_flat
);
  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [BANK_W:0] NB_EXT = (BANK_W+1)'(NUM_BANKS);

  host_op_t op;
  assign op.wr   = wr_en;
  assign op.rd   = rd_en;
  assign op.slot = addr[3:1];

  logic is_sel, bank_ok;
  assign is_sel  = (op.slot == SEL_SLOT);
  assign bank_ok = ({1'b0, bank_sel} < NB_EXT);

  bankwin_select #(.BANK_W(BANK_W)) u_sel (
    .clk(clk), .rst(rst),
    .wr_hit(op.wr && is_sel),
    .wbank(wdata[BANK_W-1:0]),
    .bank_q(bank_sel)
  );

  logic [DATA_W-1:0] words [NUM_BANKS][SLOTS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SLOTS*DATA_W-1:0] bq;
    bankwin_store #(
      .DATA_W(DATA_W), .SLOTS(SLOTS),
      .HAS_RO(b == REV_BANK), .RO_IDX(int'(REV_SLOT))
    ) u_store (
      .clk(clk), .rst(rst),
      .we(op.wr && !is_sel && bank_sel == BANK_W'(b)),
      .slot(op.slot), .wdata(wdata), .q(bq)
    );
    assign regs_flat[b*SLOTS*DATA_W +: SLOTS*DATA_W] = bq;
    for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
      assign words[b][s] = bq[s*DATA_W +: DATA_W];
    end
  end

  assign station_addr = {words[1][4], words[1][3], words[1][2]};

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (is_sel)
      rd_next = {SIG_BYTE, {(DATA_W-8-BANK_W){1'b0}}, bank_sel};
    else if (bank_ok) begin
      if (int'(bank_sel) == REV_BANK && op.slot == REV_SLOT)
        rd_next = {SIG_BYTE, REV_CODE};
      else
        rd_next = words[bank_sel[BIDX_W-1:0]][op.slot];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (op.rd) rdata <= rd_next;
  end

  assert_sig_byte_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[3:1] == 3'd7) |=> rdata[15:8] == 8'h33);
  assert_rev_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[3:1] == 3'd5 && bank_sel == 3'd3) |=> rdata == {8'h33, REV_CODE});
  assert_undef_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !bank_ok && addr[3:1] != 3'd7) |=> rdata == '0);
  assert_undef_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bank_ok && addr[3:1] != 3'd7) |=> $stable(regs_flat));
  assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_banked_regwin.sv
module sim_banked_regwin;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0] bank_sel;
  logic [47:0] station_addr;
  logic [447:0] regs_flat;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  banked_regwin u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bank_sel(bank_sel),
    .station_addr(station_addr), .regs_flat(regs_flat)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int b, input int s);
    return 16'hA000 | 16'(b << 8) | 16'(s << 4) | 16'(b ^ s);
  endfunction

  function automatic logic [15:0] slotw(input int b, input int s);
    return regs_flat[((b*7)+s)*16 +: 16];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 0);
    chk("R1 bank", bank_sel, 0);
    chk("R1 storage", 64'(regs_flat == '0), 1);
    chk("R1 station", station_addr, 0);
  endtask

  task automatic t_bank_select;
    logic [15:0] d;
    wr(4'hE, 16'hFFFB);
    chk("R2 bank", bank_sel, 3);
    rd(4'hE, d);
    chk("R3 masked", d & 16'hFF07, 16'h3303);
    chk("R3 full", d, 16'h3303);
    wr(4'hE, 16'h0002);
    rd(4'hE, d);
    chk("R2 reselect", d, 16'h3302);
  endtask

  task automatic t_storage;
    logic [15:0] d;
    for (int b = 0; b < 4; b++) begin
      wr(4'hE, 16'(b));
      for (int s = 0; s < 7; s++) wr(4'(2*s), pat(b, s));
    end
    for (int b = 0; b < 4; b++) begin
      wr(4'hE, 16'(b));
      for (int s = 0; s < 7; s++) begin
        if (!(b == 3 && s == 5)) begin
          rd(4'(2*s + 1), d);  // odd address: bit 0 ignored
          chk("R4 readback", d, pat(b, s));
          chk("R10 export", slotw(b, s), pat(b, s));
        end
      end
    end
    wr(4'hE, 0);
    wr(4'h6, 16'h1234);
    chk("R5 bank0 slot3", slotw(0, 3), 16'h1234);
    chk("R5 bank2 slot3 untouched", slotw(2, 3), pat(2, 3));
    wr(4'hE, 2);
    rd(4'h6, d);
    chk("R5 bank2 read", d, pat(2, 3));
  endtask

  task automatic t_revision;
    logic [15:0] d;
    wr(4'hE, 3);
    wr(4'hA, 16'hFFFF);
    rd(4'hA, d);
    chk("R6 revision", d, 16'h3391);
    chk("R6 export zero", slotw(3, 5), 0);
  endtask

  task automatic t_station;
    wr(4'hE, 1);
    wr(4'h4, 16'h2211);
    wr(4'h6, 16'h4433);
    wr(4'h8, 16'h6655);
    chk("R7 station", station_addr, 48'h665544332211);
  endtask

  task automatic t_undefined;
    logic [15:0] d;
    logic [447:0] snap;
    wr(4'hE, 5);
    chk("R2 bank5", bank_sel, 5);
    snap = regs_flat;
    wr(4'h0, 16'hDEAD);
    wr(4'hC, 16'hBEEF);
    chk("R8 no write", 64'(regs_flat == snap), 1);
    rd(4'h0, d);
    chk("R8 read zero", d, 0);
    rd(4'hE, d);
    chk("R3 bank5", d, 16'h3305);
    wr(4'hE, 16'hFFF8);
    rd(4'h0, d);
    chk("R8 bank0 intact", d, pat(0, 0));
  endtask

  task automatic t_latency;
    logic [15:0] d;
    wr(4'hE, 0);
    rd(4'h2, d);
    chk("R9 value", d, pat(0, 1));
    @(negedge clk); rd_en = 1'b1; addr = 4'h4;
    #4; chk("R9 before edge", rdata, pat(0, 1));
    @(negedge clk); rd_en = 1'b0;
    chk("R9 after edge", rdata, pat(0, 2));
    wr(4'h4, 16'h5555);
    wr(4'hE, 2);
    repeat (3) @(negedge clk);
    chk("R9 hold", rdata, pat(0, 2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bank_select();
    t_storage();
    t_revision();
    t_station();
    t_undefined();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule